// File: doc/BRIEF.md
# SRAM Privilege Watermark Filter

This block guards one on-chip SRAM region of 32 Kbyte. A single configuration register holds a length field. The length sets how far a low unprivileged zone reaches up from the region base, in 1-Kbyte pages. Offsets above that zone are reserved for privileged masters. On every cycle the access-check port takes an offset and a privileged flag and answers allow or deny. An unprivileged access that lands above the zone is blocked with a deny pulse for that cycle.

The register is reached through a small slave port whose writes carry secure and privileged qualifiers. Three inputs control write acceptance:

- a lock input, which freezes the register;
- the region's secure option, which narrows writers down to secure privileged ones;
- a global security enable. When this enable is low the whole region is unprivileged, and the register still accepts writes and reads.

Top module: `sram_priv_watermark`

## Requirements
- R1: After reset the register reads 0x0FFF_0000, so the length field (bits 27:16) holds 0xFFF.
- R2: Bits 31:28 and 15:0 of the register always read zero, and writing them has no effect. Only write-data bits 27:16 are stored.
- R3: When `regionSecure` is 1, a write is accepted only when `cfgSecure` = 1 and `cfgPriv` = 1. A non-secure privileged write leaves the register unchanged.
- R4: When `regionSecure` is 0, privileged writes are accepted whether `cfgSecure` is 0 or 1.
- R5: A write with `cfgPriv` = 0 never changes the register.
- R6: While `cfgLock` is 1, no write changes the register.
- R7: With `secEnable` = 1, a valid unprivileged access is allowed when offset bits 14:10 are below the length and denied otherwise. A length of 0 denies every unprivileged offset.
- R8: Any length of 0x020 or more, including 0x800 to 0xFFF, makes the whole region 0x0000 to 0x7FFF unprivileged.
- R9: With `secEnable` = 0, every valid access is allowed whatever the length. The register stays writable and readable.
- R10: A valid privileged access (`accPriv` = 1) is always allowed.
- R11: `accAllow` and `accDeny` are both 0 when `accValid` is 0. They are never 1 together, and exactly one of them is 1 for each valid access.
- R12: An accepted write affects the access check from the cycle after the accepting clock edge. An access in the same cycle as the write sees the old length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| secEnable | input | 1 | Global security enable; 0 bypasses the check |
| regionSecure | input | 1 | Region secure option; 1 restricts writes to secure privileged |
| cfgLock | input | 1 | Configuration lock; 1 ignores all writes |
| cfgWrEn | input | 1 | Register write strobe |
| cfgWrData | input | 32 | Register write data |
| cfgSecure | input | 1 | Write attribute: secure |
| cfgPriv | input | 1 | Write attribute: privileged |
| cfgRdData | output | 32 | Register read value, available to any master |
| accValid | input | 1 | Access-check request |
| accOffset | input | 15 | Byte offset into the region |
| accPriv | input | 1 | Access attribute: privileged |
| accAllow | output | 1 | Access permitted this cycle |
| accDeny | output | 1 | Access blocked this cycle |

## Verification
The bench builds the block with its defaults: a 12-bit length field at bit 16, 15-bit offsets and 1-Kbyte pages. This yields 32 pages, while the field can hold values far above 32. That range brings saturation within reach at 0x020, 0x7FF, 0x800 and 0xFFF, and it lets the bench sweep every page boundary from length 0 up past full coverage. At each length the bench probes the last allowed offset and the first denied offset.

// File: rtl/wm_pkg.sv
package wm_pkg;

  // Strobes passed from control to datapath each cycle
  typedef struct packed {
    logic loadLen;   // capture a new length field at this edge
    logic enforce;   // the current access must respect the watermark
  } wmStrobe_t;

endpackage

// File: rtl/wm_ctrl.sv
module wm_ctrl
  import wm_pkg::*;
(
  input  logic      secEnable,
  input  logic      regionSecure,
  input  logic      cfgLock,
  input  logic      cfgWrEn,
  input  logic      cfgSecure,
  input  logic      cfgPriv,
  input  logic      accPriv,
  output wmStrobe_t strobe
);

  logic writerOk;

  // Secure option narrows the writer set to secure privileged masters
  always_comb begin
    writerOk = cfgPriv && (cfgSecure || !regionSecure);
    strobe.loadLen = cfgWrEn && writerOk && !cfgLock;
    strobe.enforce = secEnable && !accPriv;
  end

endmodule

// File: rtl/wm_dp.sv
module wm_dp
  import wm_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int LEN_W      = 12,
  parameter int FIELD_LSB  = 16,
  parameter int OFF_W      = 15,
  parameter int PAGE_SHIFT = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  wmStrobe_t         strobe,
  input  logic [LEN_W-1:0]  wrLen,
  input  logic              accValid,
  input  logic [OFF_W-1:0]  accOffset,
  output logic [DATA_W-1:0] rdData,
  output logic              accAllow,
  output logic              accDeny
);

  localparam int PG_W  = OFF_W - PAGE_SHIFT;
  localparam int PAGES = 1 << PG_W;
  localparam int SAT_W = PG_W + 1;

  logic [LEN_W-1:0] lenQ;
  logic [SAT_W-1:0] satQ;
  logic [SAT_W-1:0] satNext;
  logic [SAT_W-1:0] pageExt;
  logic             inZone;
  logic [OFF_W-1:0] unusedLowOffset;

  // Clamp the stored length to the number of pages in the region
  generate
    if (LEN_W > PG_W) begin : g_sat
      always_comb begin
        if (wrLen >= LEN_W'(PAGES)) satNext = SAT_W'(PAGES);
        else                        satNext = SAT_W'(wrLen);
      end
    end else begin : g_nosat
      always_comb satNext = SAT_W'(wrLen);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenQ <= '1;
      satQ <= (LEN_W > PG_W) ? SAT_W'(PAGES) : SAT_W'({LEN_W{1'b1}});
    end else if (strobe.loadLen) begin
      lenQ <= wrLen;
      satQ <= satNext;
    end
  end

  always_comb begin
    rdData = '0;
    rdData[FIELD_LSB +: LEN_W] = lenQ;
  end

  assign unusedLowOffset = accOffset;
  assign pageExt  = {1'b0, accOffset[OFF_W-1:PAGE_SHIFT]};
  assign inZone   = pageExt < satQ;
  assign accAllow = accValid && (!strobe.enforce || inZone);
  assign accDeny  = accValid && strobe.enforce && !inZone;

endmodule

// File: rtl/sram_priv_watermark.sv
module sram_priv_watermark
  import wm_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int LEN_W      = 12,
  parameter int FIELD_LSB  = 16,
  parameter int OFF_W      = 15,
  parameter int PAGE_SHIFT = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              secEnable,
  input  logic              regionSecure,
  input  logic              cfgLock,
  input  logic              cfgWrEn,
  input  logic [DATA_W-1:0] cfgWrData,
  input  logic              cfgSecure,
  input  logic              cfgPriv,
  output logic [DATA_W-1:0] cfgRdData,
  input  logic              accValid,
  input  logic [OFF_W-1:0]  accOffset,
  input  logic              accPriv,
  output logic              accAllow,
  output logic              accDeny
);

  wmStrobe_t         strobe;
  logic [LEN_W-1:0]  wrLen;
  logic [DATA_W-1:0] unusedWrBits;

  // Reserved data bits are dropped here
  assign wrLen        = cfgWrData[FIELD_LSB +: LEN_W];
  assign unusedWrBits = cfgWrData;

  wm_ctrl u_ctrl (
    .secEnable    (secEnable),
    .regionSecure (regionSecure),
    .cfgLock      (cfgLock),
    .cfgWrEn      (cfgWrEn),
    .cfgSecure    (cfgSecure),
    .cfgPriv      (cfgPriv),
    .accPriv      (accPriv),
    .strobe       (strobe)
  );

  wm_dp #(
    .DATA_W     (DATA_W),
    .LEN_W      (LEN_W),
    .FIELD_LSB  (FIELD_LSB),
    .OFF_W      (OFF_W),
    .PAGE_SHIFT (PAGE_SHIFT)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrLen     (wrLen),
    .accValid  (accValid),
    .accOffset (accOffset),
    .rdData    (cfgRdData),
    .accAllow  (accAllow),
    .accDeny   (accDeny)
  );

endmodule

// File: rtl/wm_chk.sv
module wm_chk #(
  parameter int DATA_W     = 32,
  parameter int LEN_W      = 12,
  parameter int FIELD_LSB  = 16,
  parameter int OFF_W      = 15,
  parameter int PAGE_SHIFT = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              secEnable,
  input logic              regionSecure,
  input logic              cfgLock,
  input logic              cfgWrEn,
  input logic [DATA_W-1:0] cfgWrData,
  input logic              cfgSecure,
  input logic              cfgPriv,
  input logic [DATA_W-1:0] cfgRdData,
  input logic              accValid,
  input logic [OFF_W-1:0]  accOffset,
  input logic              accPriv,
  input logic              accAllow,
  input logic              accDeny
);

  localparam logic [DATA_W-1:0] FIELD_MASK = {{(DATA_W-LEN_W){1'b0}}, {LEN_W{1'b1}}} << FIELD_LSB;

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRdData & ~FIELD_MASK) == '0);

  assert_nonsecure_blocked_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && regionSecure && !cfgSecure) |=> $stable(cfgRdData));

  assert_unpriv_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && !cfgPriv) |=> $stable(cfgRdData));

  assert_lock_holds_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && cfgLock) |=> $stable(cfgRdData));

  assert_bypass_allow_R9: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && !secEnable) |-> accAllow);

  assert_priv_allow_R10: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accPriv) |-> accAllow);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |-> (!accAllow && !accDeny));

  assert_one_verdict_R11: assert property (@(posedge clk) disable iff (!rstN)
    accValid |-> $onehot({accAllow, accDeny}));

endmodule

bind sram_priv_watermark wm_chk #(
  .DATA_W     (DATA_W),
  .LEN_W      (LEN_W),
  .FIELD_LSB  (FIELD_LSB),
  .OFF_W      (OFF_W),
  .PAGE_SHIFT (PAGE_SHIFT)
) u_chk (.*);

// File: tb/sram_priv_watermark_tb.sv
module sram_priv_watermark_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        secEnable = 1'b1;
  logic        regionSecure = 1'b0;
  logic        cfgLock = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [31:0] cfgWrData = '0;
  logic        cfgSecure = 1'b0;
  logic        cfgPriv = 1'b0;
  logic [31:0] cfgRdData;
  logic        accValid = 1'b0;
  logic [14:0] accOffset = '0;
  logic        accPriv = 1'b0;
  logic        accAllow;
  logic        accDeny;

  int checks = 0;
  int fails  = 0;
  logic [11:0] modelLen = 12'hFFF;

  always #5 clk = ~clk;

  sram_priv_watermark u_dut (
    .clk(clk), .rstN(rstN), .secEnable(secEnable), .regionSecure(regionSecure),
    .cfgLock(cfgLock), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .cfgSecure(cfgSecure), .cfgPriv(cfgPriv), .cfgRdData(cfgRdData),
    .accValid(accValid), .accOffset(accOffset), .accPriv(accPriv),
    .accAllow(accAllow), .accDeny(accDeny)
  );

  function automatic logic expAllow(logic [11:0] len, logic [14:0] off, logic prv, logic se);
    int sat;
    if (!se || prv) return 1'b1;
    sat = (len >= 12'h020) ? 32 : int'(len);
    return int'(off[14:10]) < sat;
  endfunction

  task automatic check32(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  // One-cycle register write, driven away from the active edge
  task automatic doWrite(logic [31:0] data, logic sec, logic prv);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrData = data; cfgSecure = sec; cfgPriv = prv;
    @(negedge clk);
    cfgWrEn = 1'b0; cfgWrData = '0;
  endtask

  task automatic chkAcc(string tag, logic [14:0] off, logic prv);
    logic ea;
    @(negedge clk);
    accValid = 1'b1; accOffset = off; accPriv = prv;
    #1;
    ea = expAllow(modelLen, off, prv, secEnable);
    check32({tag, " allow/deny"}, {30'd0, accAllow, accDeny}, {30'd0, ea, ~ea});
    accValid = 1'b0;
  endtask

  task automatic testReset();
    #1;
    check32("R1 reset value", cfgRdData, 32'h0FFF_0000);
    chkAcc("R8 reset length full zone", 15'h7FFF, 1'b0);
  endtask

  task automatic testReserved();
    regionSecure = 1'b1;
    doWrite(32'hFFFF_FFFF, 1'b1, 1'b1);
    check32("R2 reserved bits", cfgRdData, 32'h0FFF_0000);
    doWrite(32'hA5A5_5A5A, 1'b1, 1'b1);
    modelLen = 12'h5A5;
    check32("R2 field only", cfgRdData, 32'h05A5_0000);
  endtask

  task automatic testSecureOption();
    regionSecure = 1'b1;
    doWrite(32'h0003_0000, 1'b0, 1'b1);
    check32("R3 non-secure write ignored", cfgRdData, {4'h0, modelLen, 16'h0});
    doWrite(32'h0003_0000, 1'b1, 1'b1);
    modelLen = 12'h003;
    check32("R3 secure priv write", cfgRdData, 32'h0003_0000);
  endtask

  task automatic testOpenOption();
    regionSecure = 1'b0;
    doWrite(32'h0007_0000, 1'b0, 1'b1);
    modelLen = 12'h007;
    check32("R4 non-secure priv write", cfgRdData, 32'h0007_0000);
    doWrite(32'h0009_0000, 1'b1, 1'b1);
    modelLen = 12'h009;
    check32("R4 secure priv write", cfgRdData, 32'h0009_0000);
  endtask

  task automatic testUnprivWrite();
    regionSecure = 1'b0;
    doWrite(32'h0001_0000, 1'b1, 1'b0);
    check32("R5 secure unpriv ignored", cfgRdData, 32'h0009_0000);
    doWrite(32'h0001_0000, 1'b0, 1'b0);
    check32("R5 non-secure unpriv ignored", cfgRdData, 32'h0009_0000);
    chkAcc("R5 check still uses old length", 15'h2000, 1'b0);
  endtask

  task automatic testLock();
    cfgLock = 1'b1;
    doWrite(32'h0002_0000, 1'b1, 1'b1);
    check32("R6 locked write ignored", cfgRdData, 32'h0009_0000);
    chkAcc("R6 locked check unchanged", 15'h2000, 1'b0);
    cfgLock = 1'b0;
    doWrite(32'h0002_0000, 1'b1, 1'b1);
    modelLen = 12'h002;
    check32("R6 unlocked write", cfgRdData, 32'h0002_0000);
  endtask

  task automatic sweepOne(logic [11:0] len);
    int sat;
    doWrite({4'h0, len, 16'h0}, 1'b1, 1'b1);
    modelLen = len;
    sat = (len >= 12'h020) ? 32 : int'(len);
    if (sat > 0) chkAcc("R7 last allowed offset", 15'(sat * 1024 - 1), 1'b0);
    if (sat < 32) chkAcc("R7 first denied offset", 15'(sat * 1024), 1'b0);
    if (sat >= 32) chkAcc("R8 saturated top offset", 15'h7FFF, 1'b0);
    chkAcc("R10 privileged access", 15'h7FFF, 1'b1);
  endtask

  task automatic testSweep();
    secEnable = 1'b1;
    for (int l = 0; l <= 34; l++) sweepOne(12'(l));
    sweepOne(12'h7FF);
    sweepOne(12'h800);
    sweepOne(12'hFFF);
    sweepOne(12'h000);
    chkAcc("R7 zero length offset 0", 15'h0000, 1'b0);
  endtask

  task automatic testBypass();
    secEnable = 1'b0;
    doWrite(32'h0000_0000, 1'b1, 1'b1);
    modelLen = 12'h000;
    check32("R9 write while disabled", cfgRdData, 32'h0000_0000);
    chkAcc("R9 bypass offset 0", 15'h0000, 1'b0);
    chkAcc("R9 bypass top", 15'h7FFF, 1'b0);
    secEnable = 1'b1;
    chkAcc("R9 re-enabled enforces", 15'h0000, 1'b0);
  endtask

  task automatic testIdle();
    @(negedge clk);
    accValid = 1'b0; accOffset = 15'h7FFF; accPriv = 1'b0;
    #1;
    check32("R11 idle outputs", {30'd0, accAllow, accDeny}, 32'd0);
  endtask

  task automatic testTiming();
    doWrite(32'h0002_0000, 1'b1, 1'b1);
    modelLen = 12'h002;
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrData = 32'h0004_0000; cfgSecure = 1'b1; cfgPriv = 1'b1;
    accValid = 1'b1; accOffset = 15'h0C00; accPriv = 1'b0;
    #1;
    check32("R12 same cycle old length", {30'd0, accAllow, accDeny}, 32'd1);
    @(negedge clk);
    cfgWrEn = 1'b0;
    modelLen = 12'h004;
    #1;
    check32("R12 next cycle new length", {30'd0, accAllow, accDeny}, 32'd2);
    accValid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testReserved();
    testSecureOption();
    testOpenOption();
    testUnprivWrite();
    testLock();
    testSweep();
    testBypass();
    testIdle();
    testTiming();
    repeat (2) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule